// File: doc/BRIEF.md
# Camera Control Register I2C Slave

This block is an I2C target that gives a host access to a small bank of 8-bit image-sensor control registers. The registers hold white-balance gains, saturation, contrast, brightness, sharpness and an auto-gain value. The block samples SCL and SDA from the pads through two-flop synchronisers on the system clock. It drives SDA only as an open-drain pull-down enable. Its slave address is chosen by three select pins when a multi-device pin is high. When that pin is low, the block answers on one fixed address.

A write cycle sends the slave address, then a register pointer, then any number of data bytes. A read cycle carries no pointer. It streams data starting at the pointer left by the previous cycle. The pointer advances after every data byte in both directions and keeps its last value. To restart a read at a new location, the host first sends a write cycle that carries only the pointer byte.

The register values are always visible as parallel outputs. The gain register is also fed by an auto-gain source.

Top module: `cam_reg_i2c_slave`

## Requirements
- R1: With `multi_en` high, the block acknowledges write address `0xC0 + 4*cs_sel` and the matching read address, which has bit 0 set. It does not acknowledge `0xC0` unless `cs_sel` is 0.
- R2: With `multi_en` low, the block acknowledges only `0xC0` (write) and `0xC1` (read) for any `cs_sel`. Every other address is left unacknowledged.
- R3: In a write cycle, the byte after the address sets the register pointer and the following bytes are written to registers. The block acknowledges every byte it accepts.
- R4: The first byte of a read cycle comes from the stored pointer, and no pointer byte is sent.
- R5: The pointer increments by one after each data byte, whether written or read. The new value persists into later cycles.
- R6: During a read, data is driven MSB first and SDA is released in the acknowledge slot. After the master NACKs, SDA stays released. SDA is never pulled low while the block is idle.
- R7: After reset the outputs read gain 0x00, blue 0x80, red 0x80, saturation 0x80, contrast 0x48, brightness 0x80 and sharpness 0xC6. The pointer map is: gain 0x00, blue 0x01, red 0x02, saturation 0x03, contrast 0x05, brightness 0x06, sharpness 0x07.
- R8: Writes to pointer 0x04, to 0x08 and above, and to gain bits 7:6 have no effect. Reads of 0x04 and of 0x08 and above return 0xFF. Gain bits 7:6 read as 0.
- R9: While `agc_en` is low, the gain register is held at 0 and host writes to it are lost. While `agc_en` is high, `agc_upd` loads `agc_gain` and takes priority over a host write in the same cycle. Otherwise a host write loads bits 5:0.
- R10: A START or STOP condition inside a byte abandons the transfer. The pointer changes only when a pointer byte has been fully received, i.e. at the falling SCL edge that ends its eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| cs_sel | input | 3 | Address select in multi-device mode |
| multi_en | input | 1 | Enables pin-selected addressing |
| agc_en | input | 1 | Auto-gain enable |
| agc_upd | input | 1 | Load strobe for the auto-gain value |
| agc_gain | input | 6 | Auto-gain value |
| reg_gain | output | 6 | Gain register |
| reg_blue | output | 8 | Blue balance register |
| reg_red | output | 8 | Red balance register |
| reg_sat | output | 8 | Saturation register |
| reg_contrast | output | 8 | Contrast register |
| reg_bright | output | 8 | Brightness register |
| reg_sharp | output | 8 | Sharpness register |

## Verification
An auto-gain update and a host write to the gain register can both try to load it on the same clock. The bench holds `agc_upd` high with a fixed `agc_gain` through an entire host write to pointer 0x00, so the two loads are certain to overlap at the commit edge. It then checks that the gain output carries the auto-gain value and not the written byte. The pointer update and an aborting START or STOP can also meet. The bench cuts a pointer byte short and then reads back, which shows whether the old pointer survived.

// File: rtl/cam_reg_i2c_slave.sv
module cam_reg_i2c_slave #(
  parameter logic [7:0] ID_BASE     = 8'hC0,
  parameter logic [7:0] DEF_BAL     = 8'h80,
  parameter logic [7:0] DEF_CTR     = 8'h48,
  parameter logic [7:0] DEF_SHP     = 8'hC6,
  parameter logic [7:0] UNDEF_VAL   = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] cs_sel,
  input  logic       multi_en,
  input  logic       agc_en,
  input  logic       agc_upd,
  input  logic [5:0] agc_gain,
  output logic [5:0] reg_gain,
  output logic [7:0] reg_blue,
  output logic [7:0] reg_red,
  output logic [7:0] reg_sat,
  output logic [7:0] reg_contrast,
  output logic [7:0] reg_bright,
  output logic [7:0] reg_sharp
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;
  st_t        st;
  logic [2:0] bitcnt;
  logic [7:0] sh;
  logic       got8;
  logic [1:0] phase;
  logic       rd_mode;
  logic       macked;
  logic [7:0] sub;
  logic [7:0] rd_val;

  wire scl_s     = scl_ff[1];
  wire sda_s     = sda_ff[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  wire [7:0] id_w    = multi_en ? ID_BASE + {3'b000, cs_sel, 2'b00} : ID_BASE;
  wire       addr_hit = (sh[7:1] == id_w[7:1]);
  wire       wr_en   = (st == S_RX) && scl_fall && got8 && (phase == 2'd2)
                       && !start_det && !stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_comb begin
    case (sub)
      8'h00:   rd_val = {2'b00, reg_gain};
      8'h01:   rd_val = reg_blue;
      8'h02:   rd_val = reg_red;
      8'h03:   rd_val = reg_sat;
      8'h05:   rd_val = reg_contrast;
      8'h06:   rd_val = reg_bright;
      8'h07:   rd_val = reg_sharp;
      default: rd_val = UNDEF_VAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      got8    <= 1'b0;
      phase   <= '0;
      rd_mode <= 1'b0;
      macked  <= 1'b0;
      sub     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      st     <= S_RX;
      bitcnt <= '0;
      got8   <= 1'b0;
      phase  <= 2'd0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) got8 <= 1'b1;
          end else if (scl_fall && got8) begin
            got8 <= 1'b0;
            case (phase)
              2'd0: begin
                if (addr_hit) begin
                  rd_mode <= sh[0];
                  sda_oe  <= 1'b1;
                  phase   <= 2'd1;
                  st      <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end
              2'd1: begin
                sub    <= sh;
                sda_oe <= 1'b1;
                phase  <= 2'd2;
                st     <= S_ACK;
              end
              default: begin
                sub    <= sub + 8'd1;
                sda_oe <= 1'b1;
                st     <= S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              sh     <= rd_val;
              sda_oe <= ~rd_val[7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              sub    <= sub + 8'd1;
              st     <= S_MACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            macked <= ~sda_s;
          end else if (scl_fall) begin
            if (macked) begin
              sh     <= rd_val;
              sda_oe <= ~rd_val[7];
              st     <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_blue     <= DEF_BAL;
      reg_red      <= DEF_BAL;
      reg_sat      <= DEF_BAL;
      reg_contrast <= DEF_CTR;
      reg_bright   <= DEF_BAL;
      reg_sharp    <= DEF_SHP;
    end else if (wr_en) begin
      case (sub)
        8'h01: reg_blue     <= sh;
        8'h02: reg_red      <= sh;
        8'h03: reg_sat      <= sh;
        8'h05: reg_contrast <= sh;
        8'h06: reg_bright   <= sh;
        8'h07: reg_sharp    <= sh;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       reg_gain <= '0;
    else if (!agc_en)                 reg_gain <= '0;
    else if (agc_upd)                 reg_gain <= agc_gain;
    else if (wr_en && sub == 8'h00)   reg_gain <= sh[5:0];
  end

  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe));

  a_r9_gain_off: assert property (@(posedge clk) disable iff (!rst_n)
    !agc_en |=> (reg_gain == 6'd0));

  a_r9_gain_upd: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_en && agc_upd) |=> (reg_gain == $past(agc_gain)));

  a_r5_read_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && scl_fall && bitcnt == 3'd7 && !start_det && !stop_det)
      |=> (sub == $past(sub) + 8'd1));

endmodule

// File: tb/cam_reg_i2c_slave_tb.sv
module cam_reg_i2c_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       m_scl = 1'b1, m_low = 1'b0;
  logic [2:0] cs_sel = 3'd3;
  logic       multi_en = 1'b0, agc_en = 1'b0, agc_upd = 1'b0;
  logic [5:0] agc_gain = 6'd0;
  logic       sda_oe;
  logic [5:0] reg_gain;
  logic [7:0] reg_blue, reg_red, reg_sat, reg_contrast, reg_bright, reg_sharp;
  wire        sda_line = !(sda_oe || m_low);

  cam_reg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cs_sel(cs_sel), .multi_en(multi_en), .agc_en(agc_en), .agc_upd(agc_upd),
    .agc_gain(agc_gain), .reg_gain(reg_gain), .reg_blue(reg_blue), .reg_red(reg_red),
    .reg_sat(reg_sat), .reg_contrast(reg_contrast), .reg_bright(reg_bright),
    .reg_sharp(reg_sharp));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_byte;
  event       rd_ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (20) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wq(); m_scl = 1'b1; wq(); m_low = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wq(); m_scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = !b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; wq(); m_scl = 1'b1; wq();
    ack = !sda_line;
    m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit ack);
    logic [7:0] b;
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq(); b[i] = sda_line; m_scl = 1'b0;
    end
    m_low = ack; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq(); m_low = 1'b0;
    got_byte = b;
    -> rd_ev;
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] id, input logic [7:0] s, input int n,
                    input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                    input string tag);
    bit a;
    logic [7:0] d[3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    i2c_start();
    send_byte(id, a); chk(a, tag, a, 1);
    send_byte(s, a);  chk(a, tag, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); chk(a, tag, a, 1);
    end
    i2c_stop();
  endtask

  task automatic rd(input logic [7:0] id, input int n);
    bit a;
    i2c_start();
    send_byte(id, a); chk(a, "R4 read address ack", a, 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1);
    @(negedge clk);
    chk(!sda_oe, "R6 released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic addr_only(input logic [7:0] id, input bit exp_ack, input string tag);
    bit a;
    i2c_start();
    send_byte(id, a);
    chk(a == exp_ack, tag, a, exp_ack);
    i2c_stop();
  endtask

  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected read byte", got_byte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got_byte == e, t, got_byte, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R7 reset values
    chk(reg_gain == 6'h00 && reg_blue == 8'h80 && reg_red == 8'h80 && reg_sat == 8'h80,
        "R7 reset gain/blue/red/sat", {reg_gain, reg_blue}, 16'h0080);
    chk(reg_contrast == 8'h48 && reg_bright == 8'h80 && reg_sharp == 8'hC6,
        "R7 reset contrast/bright/sharp", {reg_contrast, reg_bright, reg_sharp}, 24'h4880C6);
    chk(!sda_oe, "R6 idle released", sda_oe, 0);

    // R3 single write, R2 single-ID mode
    wr(8'hC0, 8'h01, 1, 8'h11, 0, 0, "R3 write ack");
    chk(reg_blue == 8'h11, "R3 blue written", reg_blue, 8'h11);
    addr_only(8'hC4, 1'b0, "R2 other address not acked");
    addr_only(8'hCC, 1'b0, "R2 pin address ignored when single");

    // R1 multi-device mode
    multi_en = 1'b1;
    wr(8'hCC, 8'h02, 1, 8'h22, 0, 0, "R1 pin-selected write ack");
    chk(reg_red == 8'h22, "R1 red written", reg_red, 8'h22);
    addr_only(8'hC0, 1'b0, "R1 base address not acked when cs=3");
    multi_en = 1'b0;

    // R5 multi-byte write
    wr(8'hC0, 8'h05, 3, 8'h5A, 8'h6B, 8'h7C, "R5 burst write ack");
    chk(reg_contrast == 8'h5A && reg_bright == 8'h6B && reg_sharp == 8'h7C,
        "R5 burst write values", {reg_contrast, reg_bright, reg_sharp}, 24'h5A6B7C);

    // R4/R8 read continues at pointer 8 (reserved)
    push(8'hFF, "R8 read of reserved 08");
    rd(8'hC1, 1);

    // R4/R5 pointer set then burst read, then continuing read
    wr(8'hC0, 8'h01, 0, 0, 0, 0, "R4 pointer-only write ack");
    push(8'h11, "R4 first byte blue"); push(8'h22, "R5 red"); push(8'h80, "R5 sat");
    rd(8'hC1, 3);
    push(8'hFF, "R5 continuing read reserved 04"); push(8'h5A, "R5 continuing contrast");
    rd(8'hC1, 2);

    // R8 write across reserved location
    wr(8'hC0, 8'h03, 3, 8'h33, 8'h44, 8'h55, "R8 write ack");
    chk(reg_sat == 8'h33 && reg_contrast == 8'h55, "R8 skip reserved",
        {reg_sat, reg_contrast}, 16'h3355);
    wr(8'hC0, 8'h03, 0, 0, 0, 0, "R8 pointer ack");
    push(8'h33, "R8 sat"); push(8'hFF, "R8 reserved 04 unchanged"); push(8'h55, "R8 contrast");
    rd(8'hC1, 3);

    // R9 gain behaviour
    wr(8'hC0, 8'h00, 1, 8'h15, 0, 0, "R9 gain write ack");
    chk(reg_gain == 6'h00, "R9 gain held zero while agc off", reg_gain, 0);
    agc_en = 1'b1;
    wr(8'hC0, 8'h00, 1, 8'hFF, 0, 0, "R9 gain write ack");
    chk(reg_gain == 6'h3F, "R9 host gain write", reg_gain, 6'h3F);
    wr(8'hC0, 8'h00, 0, 0, 0, 0, "R8 pointer ack");
    push(8'h3F, "R8 gain upper bits read zero");
    rd(8'hC1, 1);
    agc_gain = 6'h2A; agc_upd = 1'b1;
    wr(8'hC0, 8'h00, 1, 8'h11, 0, 0, "R9 gain write ack");
    agc_upd = 1'b0;
    @(negedge clk);
    chk(reg_gain == 6'h2A, "R9 update beats host write", reg_gain, 6'h2A);
    agc_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(reg_gain == 6'h00, "R9 agc off clears gain", reg_gain, 0);

    // R10 abort mid pointer byte by STOP
    wr(8'hC0, 8'h05, 0, 0, 0, 0, "R10 pointer ack");
    i2c_start();
    send_byte(8'hC0, a); chk(a, "R10 address ack", a, 1);
    send_bits(8'h02, 4);
    i2c_stop();
    push(8'h55, "R10 pointer kept after STOP abort");
    rd(8'hC1, 1);
    // R10 abort by repeated START
    i2c_start();
    send_byte(8'hC0, a); chk(a, "R10 address ack", a, 1);
    send_bits(8'h01, 3);
    i2c_start();
    send_byte(8'hC1, a); chk(a, "R10 read after restart ack", a, 1);
    push(8'h6B, "R10 pointer kept after START abort");
    recv_byte(1'b0);
    i2c_stop();

    // R1 read address in multi mode
    multi_en = 1'b1; cs_sel = 3'd5;
    push(8'h7C, "R1 read via D5");
    rd(8'hD5, 1);
    multi_en = 1'b0;

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected reads seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule